// File: doc/BRIEF.md
# I2C-over-AUX EDID Reply Generator

This block models the register bank of one display auxiliary channel: a control register and five data registers. The driving side talks to it with plain register writes and reads. It answers the I2C-over-AUX requests that a display driver uses to fetch the monitor's EDID image. Software places a request word in the first data register. It then writes the control register with the send bit set. On the next clock edge the block decodes the request and turns the control register into a "done" word that carries a reply size. It also overwrites the first data register with the reply: an ACK code, and for reads one EDID byte.

The EDID image is held outside the block. The block drives a byte address and takes the byte back on the same cycle. A separate input tells the block whether an attached display is able to serve EDID over this channel. A start or restart is an address-only request with the middle-of-transaction flag set, and it can select the EDID slave at I2C address 0x50. Byte reads then walk through the image one byte per request. A stop, or a start to address 0, clears the session. The register port has no back-pressure. Every write is taken on the edge where `wr_en` is high, and a read is a combinational lookup of `rd_addr`.

Top module: `aux_edid_responder`

## Requirements
- R1: Registers are picked by the 8-bit offset: 0x10 is control, and 0x14, 0x18, 0x1C, 0x20, 0x24 are data registers 1 to 5. A write to a data register stores the word, and reading it back returns that word. Writes to any other offset are dropped, and reads of any other offset return 0.
- R2: A control write with bit 31 (send) clear changes no register and no session state.
- R3: A control write with bit 31 set loads the control register with bit 30 (done) set, bit 31 clear and the size field in bits 24:20. The size is 2 when request bit 28 (operation bit 0, meaning read) is 1, and 1 otherwise, which gives 0x4020_0000 or 0x4010_0000. The message length is taken from bits 24:20 of the written control word. The request word has the I2C address in bits 23:8 and the operation nibble in bits 31:28.
- R4: An address-only request (length 3) with request bit 30 (middle-of-transaction) clear is a stop. It clears slave selection, EDID availability and the byte pointer, and data 1 becomes 0x0000_0000.
- R5: An address-only request with bit 30 set and address 0x50 selects the EDID slave. EDID is marked available only when `dp_attached` is high. Data 1 becomes 0x0000_0000.
- R6: An address-only request with bit 30 set and address 0 clears the session like a stop.
- R7: A write operation (bit 28 clear) with a length other than 3 is acknowledged with data 1 = 0x0000_0000 and leaves the session unchanged.
- R8: A read with length 4, while the slave is selected and EDID is available, puts the EDID byte at the pointer into data 1 bits 23:16 with zeros elsewhere. The pointer then advances by one.
- R9: A read with length 4 while the slave is not selected or EDID is unavailable returns data 1 = 0x00FF_0000 and leaves the pointer unchanged.
- R10: A read with a length other than 3 or 4 updates the control register as in R3, but leaves data 1 and the pointer unchanged.
- R11: Once the pointer has reached EDID_BYTES, a selected and available read returns data 1 = 0x0000_0000 and the pointer stays put.
- R12: After reset all six registers read 0 and the session is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| dp_attached | input | 1 | Attached display serves EDID over this channel |
| edid_addr | output | 7 | EDID image byte address (current pointer) |
| edid_byte | input | 8 | EDID image byte at `edid_addr` |

## Verification
Two things land on the same clock edge: the reply overwriting data 1, and a read of data 1 through the read port. The bench holds `rd_addr` at 0x14 while it issues the send write. Before the edge the read must still show the request word. After that same edge it must show the formatted reply, so the read path never sees a half-updated word. A second pairing comes at the end of the image. There a read request and the pointer limit meet, and the bench judges by the returned zero byte and by a later stop/select sequence that restarts at byte 0.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned OFS_W      = 8;
  localparam int unsigned NUM_DATA   = 5;
  localparam int unsigned SIZE_LSB   = 20;
  localparam int unsigned SIZE_W     = 5;
  localparam int unsigned BUSY_BIT   = 31;
  localparam int unsigned DONE_BIT   = 30;

  localparam logic [OFS_W-1:0] OFS_CTRL      = 8'h10;
  localparam logic [OFS_W-1:0] OFS_DATA_BASE = 8'h14;
  localparam logic [OFS_W-1:0] OFS_STRIDE    = 8'h04;

  localparam logic [7:0]  ACK_CODE   = 8'h00;
  localparam logic [7:0]  NO_DATA    = 8'hFF;
  localparam logic [15:0] EDID_SLAVE = 16'h0050;
  localparam logic [SIZE_W-1:0] LEN_ADDR_ONLY = 5'd3;
  localparam logic [SIZE_W-1:0] LEN_READ_BYTE = 5'd4;
  localparam logic [SIZE_W-1:0] SIZE_READ     = 5'd2;
  localparam logic [SIZE_W-1:0] SIZE_OTHER    = 5'd1;

  localparam int unsigned OP_READ_BIT = 0;
  localparam int unsigned OP_MOT_BIT  = 2;

  typedef enum logic [1:0] {
    REQ_ADDR_ONLY = 2'd0,
    REQ_WRITE     = 2'd1,
    REQ_READ      = 2'd2
  } req_kind_e;

  typedef struct packed {
    req_kind_e            kind;
    logic                 mot;
    logic [15:0]          i2c_addr;
    logic                 len_is_read;
    logic [SIZE_W-1:0]    reply_size;
  } aux_req_t;

endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode
  import aux_edid_pkg::*;
#(
  parameter int unsigned N_DATA = NUM_DATA
) (
  input  logic [OFS_W-1:0]  offset,
  output logic              is_ctrl,
  output logic [N_DATA-1:0] data_sel
);

  assign is_ctrl = (offset == OFS_CTRL);

  for (genvar gi = 0; gi < N_DATA; gi++) begin : g_sel
    localparam logic [OFS_W-1:0] SLOT_OFS = OFS_DATA_BASE + OFS_STRIDE * OFS_W'(gi);
    assign data_sel[gi] = (offset == SLOT_OFS);
  end

endmodule

// File: rtl/aux_req_decode.sv
module aux_req_decode
  import aux_edid_pkg::*;
(
  input  logic [31:8]       req_word,
  input  logic [SIZE_W-1:0] msg_len,
  output aux_req_t          req
);

  logic [3:0] op;

  always_comb begin
    op              = req_word[31:28];
    req.i2c_addr    = req_word[23:8];
    req.mot         = op[OP_MOT_BIT];
    req.len_is_read = (msg_len == LEN_READ_BYTE);
    req.reply_size  = op[OP_READ_BIT] ? SIZE_READ : SIZE_OTHER;
    if (msg_len == LEN_ADDR_ONLY)
      req.kind = REQ_ADDR_ONLY;
    else if (!op[OP_READ_BIT])
      req.kind = REQ_WRITE;
    else
      req.kind = REQ_READ;
  end

endmodule

// File: rtl/aux_edid_session.sv
module aux_edid_session
  import aux_edid_pkg::*;
#(
  parameter int unsigned EDID_BYTES = 128,
  parameter int unsigned PTR_W      = $clog2(EDID_BYTES + 1),
  parameter int unsigned ADDR_W     = $clog2(EDID_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  aux_req_t          req,
  input  logic              dp_attached,
  input  logic [7:0]        edid_byte,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              sel_q,
  output logic              avail_q,
  output logic              reply_we,
  output logic [7:0]        reply_byte
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(EDID_BYTES);

  logic             sel_d, avail_d;
  logic [PTR_W-1:0] ptr_d;
  logic             at_end;

  assign rom_addr = ptr_q[ADDR_W-1:0];
  assign at_end   = (ptr_q >= PTR_END);

  always_comb begin
    sel_d      = sel_q;
    avail_d    = avail_q;
    ptr_d      = ptr_q;
    reply_we   = 1'b0;
    reply_byte = 8'h00;
    if (send) begin
      unique case (req.kind)
        REQ_ADDR_ONLY: begin
          reply_we = 1'b1;
          if (!req.mot || req.i2c_addr == 16'h0000) begin
            sel_d   = 1'b0;
            avail_d = 1'b0;
            ptr_d   = '0;
          end else if (req.i2c_addr == EDID_SLAVE) begin
            sel_d   = 1'b1;
            avail_d = dp_attached;
          end
        end
        REQ_WRITE: begin
          reply_we = 1'b1;
        end
        REQ_READ: begin
          if (req.len_is_read) begin
            reply_we = 1'b1;
            if (sel_q && avail_q) begin
              if (!at_end) begin
                reply_byte = edid_byte;
                ptr_d      = ptr_q + 1'b1;
              end
            end else begin
              reply_byte = NO_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      avail_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      sel_q   <= sel_d;
      avail_q <= avail_d;
      ptr_q   <= ptr_d;
    end
  end

endmodule

// File: rtl/aux_edid_responder.sv
module aux_edid_responder
  import aux_edid_pkg::*;
#(
  parameter int unsigned EDID_BYTES = 128,
  parameter int unsigned PTR_W      = $clog2(EDID_BYTES + 1),
  parameter int unsigned ADDR_W     = $clog2(EDID_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              dp_attached,
  output logic [ADDR_W-1:0] edid_addr,
  input  logic [7:0]        edid_byte
);

  logic [WORD_W-1:0]                ctrl_q;
  logic [NUM_DATA-1:0][WORD_W-1:0]  data_q;

  logic                wr_ctrl;
  logic [NUM_DATA-1:0] wr_sel;
  logic                rd_ctrl;
  logic [NUM_DATA-1:0] rd_sel;
  logic                send;
  aux_req_t            req;
  logic [PTR_W-1:0]    ptr_q;
  logic                sel_q, avail_q;
  logic                reply_we;
  logic [7:0]          reply_byte;
  logic [WORD_W-1:0]   reply_word;
  logic [WORD_W-1:0]   done_word;

  aux_reg_decode #(.N_DATA(NUM_DATA)) u_wr_dec (
    .offset   (wr_addr),
    .is_ctrl  (wr_ctrl),
    .data_sel (wr_sel)
  );

  aux_reg_decode #(.N_DATA(NUM_DATA)) u_rd_dec (
    .offset   (rd_addr),
    .is_ctrl  (rd_ctrl),
    .data_sel (rd_sel)
  );

  aux_req_decode u_req (
    .req_word (data_q[0][31:8]),
    .msg_len  (wr_data[SIZE_LSB +: SIZE_W]),
    .req      (req)
  );

  assign send = wr_en && wr_ctrl && wr_data[BUSY_BIT];

  aux_edid_session #(
    .EDID_BYTES (EDID_BYTES),
    .PTR_W      (PTR_W),
    .ADDR_W     (ADDR_W)
  ) u_sess (
    .clk         (clk),
    .rst_n       (rst_n),
    .send        (send),
    .req         (req),
    .dp_attached (dp_attached),
    .edid_byte   (edid_byte),
    .rom_addr    (edid_addr),
    .ptr_q       (ptr_q),
    .sel_q       (sel_q),
    .avail_q     (avail_q),
    .reply_we    (reply_we),
    .reply_byte  (reply_byte)
  );

  always_comb begin
    reply_word = {ACK_CODE, reply_byte, 16'h0000};
    done_word  = '0;
    done_word[DONE_BIT] = 1'b1;
    done_word[SIZE_LSB +: SIZE_W] = req.reply_size;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (send)
      ctrl_q <= done_word;
  end

  for (genvar gi = 0; gi < NUM_DATA; gi++) begin : g_data
    if (gi == 0) begin : g_reply_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          data_q[gi] <= '0;
        else if (reply_we)
          data_q[gi] <= reply_word;
        else if (wr_en && wr_sel[gi])
          data_q[gi] <= wr_data;
      end
    end else begin : g_plain_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          data_q[gi] <= '0;
        else if (wr_en && wr_sel[gi])
          data_q[gi] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ctrl)
      rd_data = ctrl_q;
    for (int i = 0; i < NUM_DATA; i++)
      if (rd_sel[i])
        rd_data = data_q[i];
  end

endmodule

// File: rtl/aux_edid_checker.sv
module aux_edid_checker #(
  parameter int unsigned EDID_BYTES = 128,
  parameter int unsigned PTR_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      data2_q,
  input logic [PTR_W-1:0] ptr_q,
  input logic             sel_q,
  input logic             avail_q
);

  logic ctl_wr;
  assign ctl_wr = wr_en && (wr_addr == 8'h10);

  a_r1_data_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h18) |=> (data2_q == $past(wr_data)));

  a_r2_idle_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wr_data[31]) |=> (ctrl_q == $past(ctrl_q) && ptr_q == $past(ptr_q)));

  a_r3_done_word: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[31]) |=>
      (ctrl_q[31:30] == 2'b01 && (ctrl_q[24:20] == 5'd1 || ctrl_q[24:20] == 5'd2)));

  a_r5_avail_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q |-> sel_q);

  a_r9_ptr_hold_unavail: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[31] && !(sel_q && avail_q)) |=> (ptr_q == $past(ptr_q)));

  a_r10_ptr_hold_badlen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[31] && wr_data[24:20] != 5'd3 && wr_data[24:20] != 5'd4)
      |=> (ptr_q == $past(ptr_q)));

  a_r11_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(EDID_BYTES));

endmodule

bind aux_edid_responder aux_edid_checker #(
  .EDID_BYTES (EDID_BYTES),
  .PTR_W      (PTR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .ctrl_q  (ctrl_q),
  .data2_q (data_q[1]),
  .ptr_q   (ptr_q),
  .sel_q   (sel_q),
  .avail_q (avail_q)
);

// File: tb/aux_edid_responder_bench.sv
`timescale 1ns/1ps
module aux_edid_responder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        dp_attached = 1'b1;
  logic [6:0]  edid_addr;
  logic [7:0]  edid_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_val(input int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction

  assign edid_byte = rom_val(int'(edid_addr));

  aux_edid_responder u_aux_edid_responder (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .dp_attached (dp_attached), .edid_addr (edid_addr), .edid_byte (edid_byte)
  );

  typedef struct packed {
    logic [31:0] req;
    logic [31:0] ctl;
    logic [31:0] exp_ctl;
    logic [31:0] exp_d1;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h5000_0000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}, // R9 unselected read
    '{32'h4000_5000, 32'h8030_0000, 32'h4010_0000, 32'h0000_0000}, // R5 select
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0003_0000}, // R8 byte 0
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h000A_0000}, // R8 byte 1
    '{32'h5000_5000, 32'h8020_0000, 32'h4020_0000, 32'h5000_5000}, // R10 bad length
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0011_0000}, // R8 byte 2
    '{32'h4000_5000, 32'h8050_0000, 32'h4010_0000, 32'h0000_0000}, // R7 write ack
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0018_0000}, // R8 byte 3
    '{32'h1000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R4 stop
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}, // R4 cleared
    '{32'h5000_5000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R5 reselect
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h0003_0000}, // R4 pointer restarted
    '{32'h5000_0000, 32'h8030_0000, 32'h4020_0000, 32'h0000_0000}, // R6 address 0
    '{32'h5000_5000, 32'h8040_0000, 32'h4020_0000, 32'h00FF_0000}  // R6 cleared
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic send(input logic [31:0] req, input logic [31:0] ctl);
    reg_write(8'h14, req);
    reg_write(8'h10, ctl);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset values
    for (int i = 0; i < 6; i++) begin
      reg_read(8'h10 + 8'(4 * i), v);
      check("R12 reset register", v, 32'h0);
    end

    // Vector table
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].req, VECS[i].ctl);
      reg_read(8'h10, v);
      check($sformatf("R3 row %0d control", i), v, VECS[i].exp_ctl);
      reg_read(8'h14, v);
      check($sformatf("R8 row %0d data1", i), v, VECS[i].exp_d1);
    end

    // R5: no display attached -> unavailable
    dp_attached = 1'b0;
    send(32'h4000_5000, 32'h8030_0000);
    send(32'h5000_5000, 32'h8040_0000);
    reg_read(8'h14, v);
    check("R5 select without display", v, 32'h00FF_0000);
    dp_attached = 1'b1;

    // R2: control write without send bit
    reg_write(8'h10, 32'h0040_0000);
    reg_read(8'h10, v);
    check("R2 control unchanged", v, 32'h4020_0000);
    reg_read(8'h14, v);
    check("R2 data1 unchanged", v, 32'h00FF_0000);

    // R1: data registers and unmapped offsets
    for (int i = 1; i < 5; i++)
      reg_write(8'h14 + 8'(4 * i), 32'hA5A5_0000 + 32'(i));
    reg_write(8'h28, 32'hDEAD_BEEF);
    reg_write(8'h0C, 32'hDEAD_BEEF);
    for (int i = 1; i < 5; i++) begin
      reg_read(8'h14 + 8'(4 * i), v);
      check("R1 data readback", v, 32'hA5A5_0000 + 32'(i));
    end
    reg_read(8'h28, v);
    check("R1 unmapped read 0x28", v, 32'h0);
    reg_read(8'h0C, v);
    check("R1 unmapped read 0x0C", v, 32'h0);

    // R11: walk the full image, then the end
    send(32'h0000_0000, 32'h8030_0000);
    send(32'h4000_5000, 32'h8030_0000);
    for (int i = 0; i < 128; i++) begin
      send(32'h5000_5000, 32'h8040_0000);
      reg_read(8'h14, v);
      check("R8 image walk", v, {8'h00, rom_val(i), 16'h0000});
    end
    for (int i = 0; i < 2; i++) begin
      send(32'h5000_5000, 32'h8040_0000);
      reg_read(8'h14, v);
      check("R11 past end", v, 32'h0);
      reg_read(8'h10, v);
      check("R11 control still done", v, 32'h4020_0000);
    end

    // Same-cycle: reply write vs read of data 1
    send(32'h0000_0000, 32'h8030_0000);
    send(32'h4000_5000, 32'h8030_0000);
    reg_write(8'h14, 32'h5000_5000);
    rd_addr = 8'h14;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h10; wr_data = 32'h8040_0000;
    #1;
    check("R8 data1 before reply edge", rd_data, 32'h5000_5000);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R8 data1 after reply edge", rd_data, 32'h0003_0000);

    finish_run();
  end

endmodule